// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Checker

This block computes a cyclic redundancy check one bit per clock for a generator polynomial whose degree and lower coefficients are parameters. Message bits arrive on a single-bit valid/ready input that also carries a frame-start marker and a frame-end marker. The hardware forms the remainder of the message multiplied by x^r, where r is the generator degree.

In encode mode each accepted message bit is passed straight to the output in the same cycle. After the final message bit the unit holds off its input for r cycles and shifts the r-bit remainder out, most significant bit first. The output stream then forms a codeword that divides exactly by the generator. In check mode the unit takes a whole codeword, produces no output stream, and one cycle after the final bit it pulses a done strobe with a pass flag. The pass flag is high when the remainder is zero.

The mode is sampled on the beat that carries the start marker and holds for the whole frame. Taps are given as the generator without its leading term. For example, x^3+x+1 has degree 3 and taps 3'b011.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, and `out_valid`, `out_last` and `chk_done` are 0.
- R2: Outside the remainder tail, `in_ready` is 1 and the unit accepts one bit in every cycle in which `in_valid` is 1.
- R3: In encode mode (`mode_chk`=0), an accepted bit appears in the same cycle on `out_bit` with `out_valid`=1.
- R4: In encode mode, in the r cycles after the cycle that accepts the bit marked `in_last`, `in_ready` is 0 and `out_valid` is 1. `out_last` is 1 only in the r-th of those cycles.
- R5: The r tail bits are the remainder of the message times x^r divided by the generator, sent MSB first. With generator 1011 and message 1101 the tail is 001.
- R6: A beat with `in_start`=1 begins a new frame from a zero register, discarding any unfinished frame.
- R7: In check mode, one cycle after the bit marked `in_last` is accepted, `chk_done` is 1 for that cycle only. In that cycle `chk_pass` is 1 exactly when the codeword leaves remainder zero (1101001 passes for generator 1011).
- R8: In check mode `out_valid` stays 0. In encode mode `chk_done` stays 0.
- R9: While the tail runs, `in_valid` and `in_bit` have no effect on the emitted remainder.
- R10: The mode is sampled on the start beat. A change of `mode_chk` later in the frame does not change how that frame is treated.
- R11: Cycles with `in_valid`=0 inside a frame leave the remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_chk | input | 1 | 0 = encode, 1 = check; sampled with the start beat |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Unit can accept a bit |
| in_bit | input | 1 | Message or codeword bit, MSB first |
| in_start | input | 1 | Bit is the first of a frame |
| in_last | input | 1 | Bit is the last of a frame |
| out_valid | output | 1 | Output bit present (encode mode only) |
| out_bit | output | 1 | Codeword bit |
| out_last | output | 1 | Final codeword bit |
| chk_done | output | 1 | Check result strobe |
| chk_pass | output | 1 | Remainder was zero (valid with chk_done) |

## Verification
The hardest situations to reach from the ports are those where input activity overlaps the tail or a frame is cut short. While the remainder is still being shifted out, the bench keeps `in_valid` high with changing bits. It also starts a new frame in the middle of an old one, and it flips `mode_chk` partway through frames. After each of these it compares the next emitted remainder or check verdict with hand-computed division results. Stall cycles are inserted between message bits so that the register is seen to hold across idle cycles.

// File: rtl/crc_serial_pkg.sv
// Shared types for the bit-serial CRC unit.
// Assumes: none beyond standard SystemVerilog.
package crc_serial_pkg;
    // Phase of the frame sequencer: taking input bits, or emitting the remainder tail.
    typedef enum logic {
        PH_DATA = 1'b0,
        PH_TAIL = 1'b1
    } crc_phase_t;
endpackage

// File: rtl/crc_div_reg.sv
// Remainder register of the augmented division.
// Each step shifts left, takes in one bit and folds in the taps when the
// bit leaving the top is 1. On the final encode beat it also runs DEG zero
// steps in one cycle, so the register holds the finished remainder. During
// the tail it shifts left with zero fill so the MSB can be sent out.
// Assumes: DEG >= 2; TAPS is the generator without its leading 1.
module crc_div_reg #(
    parameter int          DEG  = 3,
    parameter logic [DEG-1:0] TAPS = 3'b011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           clear,
    input  logic           din,
    input  logic           finish_aug,
    input  logic           shift_out,
    output logic [DEG-1:0] rem_q,
    output logic [DEG-1:0] rem_step
);
    // One division step on a given register value and input bit.
    function automatic logic [DEG-1:0] div_step(input logic [DEG-1:0] r, input logic b);
        logic [DEG-1:0] s;
        s = {r[DEG-2:0], b};
        if (r[DEG-1]) s = s ^ TAPS;
        return s;
    endfunction

    logic [DEG-1:0] base;
    logic [DEG-1:0] aug_val;

    // Starting value for this beat: zero on a frame start.
    always_comb base = clear ? '0 : rem_q;

    // Result of the current input bit.
    always_comb rem_step = div_step(base, din);

    // Result after the appended zero bits, computed in one go.
    always_comb begin
        aug_val = rem_step;
        for (int i = 0; i < DEG; i++) aug_val = div_step(aug_val, 1'b0);
    end

    // Register update: step, finish with the zero bits, or shift the remainder out.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rem_q <= '0;
        else if (step_en && finish_aug)  rem_q <= aug_val;
        else if (step_en)                rem_q <= rem_step;
        else if (shift_out)              rem_q <= {rem_q[DEG-2:0], 1'b0};
    end

    // A start beat carrying a 0 leaves the register at zero (R6).
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && clear && !din && !finish_aug) |=> (rem_q == '0));

    // Idle cycles hold the register (R11).
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !shift_out) |=> $stable(rem_q));
endmodule

// File: rtl/crc_frame_ctrl.sv
// Frame sequencer: accepts one bit per cycle and latches the mode on the
// start beat. After an encode frame it runs a DEG-cycle tail with input
// held off.
// Assumes: DEG >= 2.
module crc_frame_ctrl
    import crc_serial_pkg::*;
#(
    parameter int DEG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_last,
    input  logic mode_chk,
    output logic in_ready,
    output logic beat,
    output logic frame_chk,
    output logic tail_active,
    output logic tail_final
);
    localparam int CW = $clog2(DEG + 1);
    localparam logic [CW-1:0] TAIL_END = CW'(DEG - 1);

    crc_phase_t    phase_q;
    logic [CW-1:0] tcnt_q;
    logic          mode_q;

    // Handshake and phase decode.
    always_comb begin
        tail_active = (phase_q == PH_TAIL);
        in_ready    = !tail_active;
        beat        = in_valid && in_ready;
        frame_chk   = (beat && in_start) ? mode_chk : mode_q;
        tail_final  = tail_active && (tcnt_q == TAIL_END);
    end

    // Latch the frame mode on the start beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mode_q <= 1'b0;
        else if (beat && in_start)  mode_q <= mode_chk;
    end

    // Phase and tail counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
            tcnt_q  <= '0;
        end else if (tail_active) begin
            if (tail_final) begin
                phase_q <= PH_DATA;
                tcnt_q  <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end else if (beat && in_last && !frame_chk) begin
            phase_q <= PH_TAIL;
            tcnt_q  <= '0;
        end
    end

    // The tail never holds input ready high (R4).
    assert_tail_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tail_active |-> !in_ready);

    // The tail counter stays in range (R4).
    assert_tail_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tail_active |-> (tcnt_q <= TAIL_END));

    // An encode last beat leads into the tail (R4).
    assert_tail_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && in_last && !frame_chk) |=> tail_active);
endmodule

// File: rtl/crc_serial_unit.sv
// Top of the bit-serial CRC encoder/checker.
// In encode mode it passes message bits through and then appends the
// remainder. In check mode it reports whether the codeword leaves a zero
// remainder, one cycle after its last bit.
// Assumes: DEG >= 2; the output side never stalls.
module crc_serial_unit #(
    parameter int             DEG  = 3,
    parameter logic [DEG-1:0] TAPS = 3'b011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_chk,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_start,
    input  logic in_last,
    output logic out_valid,
    output logic out_bit,
    output logic out_last,
    output logic chk_done,
    output logic chk_pass
);
    logic           beat;
    logic           frame_chk;
    logic           tail_active;
    logic           tail_final;
    logic [DEG-1:0] rem_q;
    logic [DEG-1:0] rem_step;

    crc_frame_ctrl #(.DEG(DEG)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .in_last     (in_last),
        .mode_chk    (mode_chk),
        .in_ready    (in_ready),
        .beat        (beat),
        .frame_chk   (frame_chk),
        .tail_active (tail_active),
        .tail_final  (tail_final)
    );

    crc_div_reg #(.DEG(DEG), .TAPS(TAPS)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (beat),
        .clear      (in_start),
        .din        (in_bit),
        .finish_aug (in_last && !frame_chk),
        .shift_out  (tail_active),
        .rem_q      (rem_q),
        .rem_step   (rem_step)
    );

    // Output stream: message pass-through in encode mode, then the remainder tail.
    always_comb begin
        out_valid = (beat && !frame_chk) || tail_active;
        out_bit   = tail_active ? rem_q[DEG-1] : in_bit;
        out_last  = tail_final;
    end

    // Check verdict registered one cycle after the last codeword bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_done <= 1'b0;
            chk_pass <= 1'b0;
        end else begin
            chk_done <= beat && in_last && frame_chk;
            chk_pass <= beat && in_last && frame_chk && (rem_step == '0);
        end
    end

    // A done strobe only follows an accepted last bit of a check frame (R7).
    assert_done_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(in_valid && in_ready && in_last));

    // The output stream and the check strobe never coincide (R8).
    assert_out_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && chk_done));

    // An accepted encode bit is forwarded unchanged (R3).
    assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !frame_chk) |-> (out_valid && (out_bit == in_bit)));
endmodule

// File: tb/crc_serial_unit_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module crc_serial_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEG = 3;

    typedef struct packed {
        logic        chk;
        logic [4:0]  len;
        logic [15:0] bits;
        logic [2:0]  rem_exp;
        logic        pass_exp;
    } vec_t;

    // Hand-worked divisions by 1011.
    localparam vec_t VECS [9] = '{
        '{1'b0, 5'd4, 16'b1101,      3'b001, 1'b0},
        '{1'b0, 5'd6, 16'b110101,    3'b111, 1'b0},
        '{1'b0, 5'd1, 16'b1,         3'b011, 1'b0},
        '{1'b0, 5'd4, 16'b0000,      3'b000, 1'b0},
        '{1'b1, 5'd7, 16'b1101001,   3'b000, 1'b1},
        '{1'b1, 5'd7, 16'b1101011,   3'b000, 1'b0},
        '{1'b1, 5'd9, 16'b110101111, 3'b000, 1'b1},
        '{1'b1, 5'd4, 16'b1011,      3'b000, 1'b1},
        '{1'b1, 5'd4, 16'b1111,      3'b000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, mode_chk, in_valid, in_ready, in_bit, in_start, in_last;
    logic out_valid, out_bit, out_last, chk_done, chk_pass;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_serial_unit #(.DEG(DEG), .TAPS(3'b011)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk), .in_valid(in_valid),
        .in_ready(in_ready), .in_bit(in_bit), .in_start(in_start), .in_last(in_last),
        .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
        .chk_done(chk_done), .chk_pass(chk_pass)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one bit right after a falling edge; outputs settle before the next rise.
    task automatic drive_bit(input logic b, input logic st, input logic ls, input logic md);
        @(negedge clk);
        in_valid = 1'b1; in_bit = b; in_start = st; in_last = ls; mode_chk = md;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_bit = 1'b0;
        #1;
    endtask

    // Watch the DEG tail cycles; noisy = keep valid high with toggling bits (R9).
    task automatic watch_tail(input logic [2:0] exp, input bit noisy, input string req);
        logic [2:0] got = '0;
        bit shape_ok = 1'b1;
        for (int k = 0; k < DEG; k++) begin
            @(negedge clk);
            in_valid = noisy; in_bit = noisy ? k[0] : 1'b0;
            in_start = noisy; in_last = noisy; mode_chk = 1'b1;
            #1;
            if (in_ready || !out_valid || (out_last != (k == DEG-1))) shape_ok = 1'b0;
            got = {got[1:0], out_bit};
        end
        check(shape_ok, "R4", int'(shape_ok), 1);
        check(got == exp, req, int'(got), int'(exp));
        idle();
        check(in_ready == 1'b1, "R2", int'(in_ready), 1);
    endtask

    task automatic send_frame(input vec_t v, input bit stall);
        bit path_ok = 1'b1;
        for (int i = int'(v.len) - 1; i >= 0; i--) begin
            drive_bit(v.bits[i], i == int'(v.len) - 1, i == 0, v.chk);
            if (!in_ready) path_ok = 1'b0;
            if (!v.chk && (!out_valid || out_bit != v.bits[i])) path_ok = 1'b0;
            if (v.chk && out_valid) path_ok = 1'b0;
            if (stall && i != 0) idle();
        end
        check(path_ok, v.chk ? "R8" : "R3", int'(path_ok), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_chk = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        in_start = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready && !out_valid && !out_last && !chk_done, "R1", int'(in_ready), 1);
        @(negedge clk); rst_n = 1'b1; #1;
        check(in_ready && !out_valid && !chk_done, "R1", int'(out_valid), 0);

        // Table walk (R5 remainders, R7 verdicts).
        foreach (VECS[n]) begin
            send_frame(VECS[n], 1'b0);
            if (VECS[n].chk) begin
                idle();
                check(chk_done == 1'b1, "R7", int'(chk_done), 1);
                check(chk_pass == VECS[n].pass_exp, "R7", int'(chk_pass), int'(VECS[n].pass_exp));
                idle();
                check(chk_done == 1'b0, "R7", int'(chk_done), 0);
            end else begin
                watch_tail(VECS[n].rem_exp, 1'b0, "R5");
                check(chk_done == 1'b0, "R8", int'(chk_done), 0);
            end
        end

        // R11: stalls between bits leave the result alone.
        send_frame(VECS[0], 1'b1);
        watch_tail(3'b001, 1'b0, "R11");

        // R9: input activity during the tail is ignored.
        send_frame(VECS[1], 1'b0);
        watch_tail(3'b111, 1'b1, "R9");

        // R6: abandoned frame 111, then a new start with 1101.
        drive_bit(1'b1, 1'b1, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(VECS[0], 1'b0);
        watch_tail(3'b001, 1'b0, "R6");

        // R10: encode frame with mode flipped to check after the start beat.
        drive_bit(1'b1, 1'b1, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b1);
        drive_bit(1'b0, 1'b0, 1'b0, 1'b1);
        check(out_valid == 1'b1, "R10", int'(out_valid), 1);
        drive_bit(1'b1, 1'b0, 1'b1, 1'b1);
        watch_tail(3'b001, 1'b0, "R10");

        // R10: check frame with mode dropped to encode after the start beat.
        drive_bit(1'b1, 1'b1, 1'b0, 1'b1);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
        check(out_valid == 1'b0, "R10", int'(out_valid), 0);
        drive_bit(1'b1, 1'b0, 1'b1, 1'b0);
        idle();
        check(chk_done && chk_pass, "R10", int'(chk_pass), 1);

        // R1: reset in the middle of a tail.
        send_frame(VECS[1], 1'b0);
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check(in_ready && !out_valid, "R1", int'(in_ready), 1);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule